// File: doc/BRIEF.md
# Multi-Channel Event Flag Register

This block keeps one sticky event flag for each timer channel and shows all of them as one byte-wide status word. A channel's flag goes high when that channel reports an event. Software can see every pending event with a single read. It then clears flags by writing zeros. A zero clears a bit only if a read earlier in the same handshake saw that bit set.

Each channel holds a private arm bit. A status read arms every channel whose flag reads as 1. A new event on a channel disarms that channel. A write clears only the armed flags that receive a 0, and then it disarms every channel. An event that arrives between the read and the write therefore survives the clear, and its interrupt is kept. A level interrupt request is raised while any flag is set and its enable input is high.

Top module: `evflag_reg`

## Requirements
- R1: After reset every flag is 0, the status word reads 0x00 and the interrupt request is low.
- R2: An event pulse on channel n sets bit n of the status word (bit 0 = channel 0, bit 7 = channel 7) on the next clock edge. The per-channel flag output always equals the status word.
- R3: A write of 0 to a set flag with no earlier status read leaves the flag set.
- R4: A status read followed by a write with 0 in bit n clears flag n when the flag was read as 1. The clear shows from the cycle after the write.
- R5: A write with 1 in bit n leaves flag n unchanged.
- R6: An event on channel n after the arming read and before the clearing write disarms channel n, so that write leaves flag n set.
- R7: A status read followed by a write of 0x00 clears every flag that was read as 1. A flag that was set only after the read stays set.
- R8: If an event and a qualified clearing write hit the same channel in the same cycle, the flag stays set.
- R9: The interrupt request is high exactly when some flag n is set and its enable bit n is high.
- R10: Any write disarms all channels, so a later write of 0 with no new read clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_event_i | input | NUM_CH | One-cycle event pulse per channel |
| irq_en_i | input | NUM_CH | Per-channel interrupt enable |
| rd_stb_i | input | 1 | Status read strobe, one cycle |
| wr_stb_i | input | 1 | Status write strobe, one cycle |
| wr_data_i | input | NUM_CH | Write data, 0 requests a clear |
| rd_data_o | output | NUM_CH | Status word |
| flags_o | output | NUM_CH | Per-channel flag view |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with the default NUM_CH of 8. With that value the extreme bit positions 0 and 7 are reachable, and the clear-all write 0x00 covers the full byte. Race cases are placed on chosen channels so that a disarmed channel sits next to armed channels in the same write.

// File: rtl/evflag_pkg.sv
package evflag_pkg;
    typedef struct packed {
        logic flag;
        logic arm;
    } chan_state_t;

    localparam chan_state_t CHAN_RESET = '{flag: 1'b0, arm: 1'b0};
endpackage

// File: rtl/evflag_chan.sv
module evflag_chan
    import evflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic flag_o
);
    chan_state_t st_d, st_q;
    logic        clr_ok;

    always_comb begin
        st_d   = st_q;
        clr_ok = wr_i & ~wr_bit_i & st_q.arm;
        if (wr_i) begin
            st_d.arm = 1'b0;
        end else if (rd_i && st_q.flag) begin
            st_d.arm = 1'b1;
        end
        if (event_i) begin
            st_d.arm = 1'b0;
        end
        st_d.flag = event_i | (st_q.flag & ~clr_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CHAN_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> !flag_o);
    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        event_i |=> flag_o);
    p_unarmed_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !st_q.arm) |=> flag_o);
    p_armed_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wr_bit_i && st_q.arm && !event_i) |=> !flag_o);
    p_one_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wr_bit_i && st_q.flag) |=> flag_o);
    p_event_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        event_i |=> !st_q.arm);
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && wr_i && !wr_bit_i && st_q.arm) |=> flag_o);
    p_write_disarms_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !st_q.arm);
endmodule

// File: rtl/evflag_irq.sv
module evflag_irq #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] flags_i,
    input  logic [NUM_CH-1:0] en_i,
    output logic              irq_o
);
    logic [NUM_CH-1:0] pend;

    assign pend  = flags_i & en_i;
    assign irq_o = |pend;

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |-> !irq_o);
    p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_i == '0) |-> !irq_o);
endmodule

// File: rtl/evflag_reg.sv
module evflag_reg #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_event_i,
    input  logic [NUM_CH-1:0] irq_en_i,
    input  logic              rd_stb_i,
    input  logic              wr_stb_i,
    input  logic [NUM_CH-1:0] wr_data_i,
    output logic [NUM_CH-1:0] rd_data_o,
    output logic [NUM_CH-1:0] flags_o,
    output logic              irq_o
);
    localparam int LAST_CH = NUM_CH - 1;

    logic [NUM_CH-1:0] flag_w;

    for (genvar n = 0; n <= LAST_CH; n++) begin : g_chan
        evflag_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .event_i  (chan_event_i[n]),
            .rd_i     (rd_stb_i),
            .wr_i     (wr_stb_i),
            .wr_bit_i (wr_data_i[n]),
            .flag_o   (flag_w[n])
        );
    end

    assign flags_o   = flag_w;
    assign rd_data_o = flag_w;

    evflag_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flag_w),
        .en_i    (irq_en_i),
        .irq_o   (irq_o)
    );

    p_unread_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rd_stb_i) && !rd_stb_i && wr_stb_i && $past(wr_stb_i))
        |=> ((rd_data_o & $past(rd_data_o)) == $past(rd_data_o)));
endmodule

// File: tb/evflag_reg_tb_top.sv
module evflag_reg_tb_top;
    localparam int NCH = 8;
    localparam int MAX_CYC = 200000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] ev = '0;
    logic [NCH-1:0] en = '0;
    logic           rd = 1'b0;
    logic           wr = 1'b0;
    logic [NCH-1:0] wd = '0;
    logic [NCH-1:0] rdata;
    logic [NCH-1:0] flags;
    logic           irq;

    always #4 clk = ~clk;

    evflag_reg #(.NUM_CH(NCH)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_event_i (ev),
        .irq_en_i     (en),
        .rd_stb_i     (rd),
        .wr_stb_i     (wr),
        .wr_data_i    (wd),
        .rd_data_o    (rdata),
        .flags_o      (flags),
        .irq_o        (irq)
    );

    typedef struct {
        int             due;
        logic [NCH-1:0] f;
        logic           irq;
        string          tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always begin
        @(posedge clk);
        cyc++;
        #3;
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (rdata !== it.f || flags !== it.f || irq !== it.irq) begin
                errors++;
                $display("FAIL %s: status=%h flags=%h irq=%b expected status=%h irq=%b",
                         it.tag, rdata, flags, irq, it.f, it.irq);
            end
        end
    end

    task automatic step(input logic [NCH-1:0] e, input logic r, input logic w,
                        input logic [NCH-1:0] d, input logic [NCH-1:0] ie,
                        input logic [NCH-1:0] exp_f, input string tag);
        item_t it;
        it.due = cyc + 1;
        it.f   = exp_f;
        it.irq = |(exp_f & ie);
        it.tag = tag;
        q.push_back(it);
        ev = e; rd = r; wr = w; wd = d; en = ie;
        @(negedge clk);
        ev = '0; rd = 1'b0; wr = 1'b0; wd = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step('0, 0, 0, '0, 8'hFF, 8'h00, "R1 reset state");
        step(8'h05, 0, 0, '0, 8'hFF, 8'h05, "R2 events ch0 ch2");
        step(8'h80, 0, 0, '0, 8'h00, 8'h85, "R2 event ch7, irq masked R9");
        step('0, 0, 1, 8'h00, 8'h00, 8'h85, "R3 write 0 without read");
        step('0, 1, 0, '0, 8'h80, 8'h85, "R4 arming read, R9 irq ch7");
        step('0, 0, 1, 8'h7F, 8'h80, 8'h05, "R4 clear bit7 only");
        step('0, 1, 0, '0, 8'h00, 8'h05, "R4 arming read");
        step('0, 0, 1, 8'hFE, 8'h00, 8'h04, "R4 clear bit0");
        step('0, 1, 0, '0, 8'h00, 8'h04, "R5 arming read");
        step('0, 0, 1, 8'hFF, 8'h00, 8'h04, "R5 write ones no effect");
        step('0, 0, 1, 8'h00, 8'h00, 8'h04, "R10 write after write no clear");
        step('0, 1, 0, '0, 8'h00, 8'h04, "R6 arming read");
        step(8'h04, 0, 0, '0, 8'h00, 8'h04, "R6 event between read and write");
        step('0, 0, 1, 8'h00, 8'h04, 8'h04, "R6 flag survives write");
        step('0, 1, 0, '0, 8'h00, 8'h04, "R6 re-arm read");
        step('0, 0, 1, 8'h00, 8'h00, 8'h00, "R6 second handshake clears");
        step(8'hF0, 0, 0, '0, 8'h00, 8'hF0, "R7 events ch4..ch7");
        step('0, 1, 0, '0, 8'h00, 8'hF0, "R7 arming read");
        step(8'h01, 0, 0, '0, 8'h01, 8'hF1, "R7 late event ch0");
        step('0, 0, 1, 8'h00, 8'h01, 8'h01, "R7 clear-all keeps late flag");
        step('0, 1, 0, '0, 8'h00, 8'h01, "R7 arming read");
        step('0, 0, 1, 8'h00, 8'hFF, 8'h00, "R7 clear-all empties, R9 irq low");
        step(8'h0C, 0, 0, '0, 8'h00, 8'h0C, "R8 events ch2 ch3");
        step('0, 1, 0, '0, 8'h00, 8'h0C, "R8 arming read");
        step(8'h08, 0, 1, 8'h00, 8'h08, 8'h08, "R8 set wins over clear, R9 irq");
        step('0, 0, 0, '0, 8'h04, 8'h08, "R9 enable other channel");
        step('0, 0, 0, '0, 8'h00, 8'h08, "R9 idle hold");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual cycles=%0d expected less than %0d",
                     cyc, MAX_CYC);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule